// File: doc/BRIEF.md
# Asynchronous Target Byte Transfer Engine

This block is the target side of the asynchronous information transfer phases of a parallel peripheral bus. A controller hands it one byte request at a time: a phase (data, command, status or message), a direction for the phases that allow both, a byte to send and a flag that marks the last byte of the phase. The engine drives the three phase-select lines and then moves the byte with a fully interlocked request/acknowledge handshake. For initiator-to-target bytes it checks odd parity and returns the received byte. Asynchronous handshaking is the only mode, so the block is in that mode from reset on.

The engine also handles the initiator's attention line. When attention is raised, it inserts a message-out phase at a permitted point. Inside a command, status or message phase that point is the end of the current byte. Inside a data phase it is the end of the byte that carries the last flag. The message-out bytes are received without controller requests and are reported on the same receive port. For command bytes with a parity error, the engine counts retries. It asks the controller to repeat the command a bounded number of times and then escalates.

Bus signals are active-high at the ports; pad cells supply the bus's negative-logic levels. Only the lower eight data bits and one parity bit are used.

Top module: `async_target_xfer`

## Requirements
- R1: The phase lines {msg, cd, io} encode data-out 000, data-in 001, command 010, status 011, message-out 110 and message-in 111. Command (cmd_phase 1) is always initiator-to-target. Status (cmd_phase 2) is always target-to-initiator. Data (cmd_phase 0) and message (cmd_phase 3) follow cmd_to_init.
- R2: The phase lines change only while bus_req is low and the synchronized acknowledge is low.
- R3: Each byte completes the sequence: REQ rises, ACK rises, REQ falls, ACK falls. REQ is not raised again until ACK has been seen low.
- R4: For target-to-initiator bytes, bus_db_out and bus_dbp_out are stable for at least DESKEW_CYC cycles before REQ rises. They stay unchanged while REQ is high. bus_dbp_out makes the nine bits odd in ones.
- R5: For initiator-to-target bytes, the byte on bus_db_in is captured when ACK is seen and is reported with one rx_valid pulse. rx_perr is set when bus_db_in and bus_dbp_in together hold an even number of ones.
- R6: If attention is seen during a command, status or message phase, the engine enters message-out after the current byte completes, before it accepts another controller byte.
- R7: If attention is seen during a data phase, the engine keeps accepting data bytes. It enters message-out only after the byte flagged last.
- R8: In message-out the engine receives bytes for as long as attention stays high. The phase ends after the byte during which attention was dropped, and msgout_done pulses once at that point.
- R9: A command byte received with a parity error pulses cmd_retry for the first MAX_RETRY such errors and cmd_escalate on the next one, which also restarts the count. A good command byte flagged last clears the count.
- R10: After reset bus_req is low, the phase lines are 000, bus_db_oe is low and cmd_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Controller byte request present |
| cmd_ready | output | 1 | Engine accepts the request this cycle |
| cmd_phase | input | 2 | 0 data, 1 command, 2 status, 3 message |
| cmd_to_init | input | 1 | Direction for data and message phases |
| cmd_data | input | 8 | Byte to send to the initiator |
| cmd_last | input | 1 | Last byte of the phase |
| byte_done | output | 1 | Pulse when a controller byte completes |
| rx_valid | output | 1 | Pulse with a received byte |
| rx_data | output | 8 | Received byte |
| rx_perr | output | 1 | Parity error on the received byte |
| msgout_active | output | 1 | Engine is in the inserted message-out phase |
| msgout_done | output | 1 | Pulse at the end of message-out |
| cmd_retry | output | 1 | Pulse: repeat the command phase |
| cmd_escalate | output | 1 | Pulse: command retries exhausted |
| bus_req | output | 1 | Request line |
| bus_ack | input | 1 | Acknowledge line (asynchronous) |
| bus_atn | input | 1 | Attention line (asynchronous) |
| bus_cd | output | 1 | Control/data phase line |
| bus_io | output | 1 | Direction phase line, high toward initiator |
| bus_msg | output | 1 | Message phase line |
| bus_db_out | output | 8 | Data driven toward the initiator |
| bus_dbp_out | output | 1 | Parity driven toward the initiator |
| bus_db_oe | output | 1 | Data output enable |
| bus_db_in | input | 8 | Data from the initiator |
| bus_dbp_in | input | 1 | Parity from the initiator |

## Verification
Every cycle, the assertions check the handshake ordering. REQ never rises while the synchronized acknowledge is high, and it falls only after the acknowledge has been seen. The phase lines hold still outside the idle window. Outgoing data is stable for the deskew interval and throughout REQ high, the message-out encoding holds while that phase runs, and retry and escalate pulses follow only command parity errors. The bench scenarios show what needs a modelled initiator: the phase codes seen at each REQ, the bytes and parity that cross in each direction, and where attention inserts message-out within command and data phases. They also show the retry count clearing on a good last byte and the escalation on the error after MAX_RETRY retries.

// File: rtl/ttx_pkg.sv
// Shared types and helpers for the asynchronous target transfer engine.
// Assumes active-high signal levels; pads handle bus polarity.
package ttx_pkg;

    typedef enum logic [1:0] {
        PH_DATA = 2'd0,
        PH_CMD  = 2'd1,
        PH_STAT = 2'd2,
        PH_MSG  = 2'd3
    } ttx_phase_e;

    typedef struct packed {
        logic msg;
        logic cd;
        logic io;
    } ttx_lines_t;

    // Odd parity bit for one byte
    function automatic logic odd_par(logic [7:0] d);
        return ~^d;
    endfunction

    // Phase-line code for a controller phase and direction
    function automatic ttx_lines_t phase_lines(ttx_phase_e ph, logic to_init);
        ttx_lines_t l;
        case (ph)
            PH_DATA: l = '{msg: 1'b0, cd: 1'b0, io: to_init};
            PH_CMD:  l = '{msg: 1'b0, cd: 1'b1, io: 1'b0};
            PH_STAT: l = '{msg: 1'b0, cd: 1'b1, io: 1'b1};
            default: l = '{msg: 1'b1, cd: 1'b1, io: to_init};
        endcase
        return l;
    endfunction

endpackage

// File: rtl/ttx_sync.sv
// Multi-stage synchronizer for asynchronous bus inputs.
// Assumes each bit is sampled independently; STAGES >= 1.
module ttx_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop samples the raw line
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= d_async;
                end
            end else begin : g_next
                // Later flops settle metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign d_sync = stage_q[STAGES-1];

endmodule

// File: rtl/ttx_hs.sv
// Handshake sequencer: phase-line control, REQ/ACK interlock, parity,
// and insertion of message-out on attention.
// Assumes ack_s and atn_s are already synchronized to clk.
module ttx_hs
    import ttx_pkg::*;
#(
    parameter int DESKEW_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ack_s,
    input  logic       atn_s,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [1:0] cmd_phase,
    input  logic       cmd_to_init,
    input  logic [7:0] cmd_data,
    input  logic       cmd_last,
    output logic       byte_done,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_perr,
    output logic       rx_is_cmd,
    output logic       rx_last,
    output logic       msgout_active,
    output logic       msgout_done,
    output logic       bus_req,
    output ttx_lines_t lines,
    output logic [7:0] db_out,
    output logic       dbp_out,
    output logic       db_oe,
    input  logic [7:0] db_in,
    input  logic       dbp_in
);
    localparam int CW = $clog2(DESKEW_CYC + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(DESKEW_CYC - 1);

    typedef enum logic [1:0] {S_IDLE, S_SETUP, S_REQ, S_WAIT} st_e;

    st_e        state;
    logic [CW-1:0] cnt;
    ttx_lines_t lines_r;
    logic [7:0] db_r;
    logic       dbp_r;
    ttx_phase_e phase_r;
    logic       last_r;
    logic       in_mo;
    logic       data_open;
    logic       go_mo;

    // Message-out may start only between bytes and outside an open data phase
    always_comb begin
        go_mo     = (state == S_IDLE) && !ack_s && atn_s && !data_open;
        cmd_ready = (state == S_IDLE) && !ack_s && !(atn_s && !data_open);
    end

    // Main sequencer: setup, REQ high, REQ low waiting for ACK release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            cnt         <= '0;
            lines_r     <= '0;
            db_r        <= '0;
            dbp_r       <= 1'b1;
            phase_r     <= PH_DATA;
            last_r      <= 1'b0;
            in_mo       <= 1'b0;
            data_open   <= 1'b0;
            rx_valid    <= 1'b0;
            rx_data     <= '0;
            rx_perr     <= 1'b0;
            rx_is_cmd   <= 1'b0;
            rx_last     <= 1'b0;
            byte_done   <= 1'b0;
            msgout_done <= 1'b0;
        end else begin
            rx_valid    <= 1'b0;
            byte_done   <= 1'b0;
            msgout_done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (go_mo) begin
                        lines_r <= '{msg: 1'b1, cd: 1'b1, io: 1'b0};
                        phase_r <= PH_MSG;
                        last_r  <= 1'b0;
                        in_mo   <= 1'b1;
                        cnt     <= '0;
                        state   <= S_SETUP;
                    end else if (cmd_valid && cmd_ready) begin
                        lines_r <= phase_lines(ttx_phase_e'(cmd_phase), cmd_to_init);
                        phase_r <= ttx_phase_e'(cmd_phase);
                        last_r  <= cmd_last;
                        db_r    <= cmd_data;
                        dbp_r   <= odd_par(cmd_data);
                        cnt     <= '0;
                        state   <= S_SETUP;
                    end
                end
                S_SETUP: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST_CNT) state <= S_REQ;
                end
                S_REQ: begin
                    if (ack_s) begin
                        state <= S_WAIT;
                        if (!lines_r.io) begin
                            rx_valid  <= 1'b1;
                            rx_data   <= db_in;
                            rx_perr   <= ~(^{db_in, dbp_in});
                            rx_is_cmd <= (phase_r == PH_CMD) && !in_mo;
                            rx_last   <= last_r;
                        end
                    end
                end
                default: begin
                    if (!ack_s) begin
                        cnt <= '0;
                        if (in_mo) begin
                            if (atn_s) begin
                                state <= S_SETUP;
                            end else begin
                                in_mo       <= 1'b0;
                                msgout_done <= 1'b1;
                                state       <= S_IDLE;
                            end
                        end else begin
                            byte_done <= 1'b1;
                            state     <= S_IDLE;
                            if (phase_r == PH_DATA) data_open <= !last_r;
                        end
                    end
                end
            endcase
        end
    end

    assign bus_req       = (state == S_REQ);
    assign lines         = lines_r;
    assign db_out        = db_r;
    assign dbp_out       = dbp_r;
    assign db_oe         = lines_r.io && (state != S_IDLE);
    assign msgout_active = in_mo;

    // ---------------- assertions ----------------
    logic [CW-1:0] stab_cnt;
    logic [8:0]    db_prev;

    // Cycles the outgoing byte has been stable (checker support)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stab_cnt <= '0;
            db_prev  <= {1'b1, 8'h00};
        end else begin
            db_prev <= {dbp_r, db_r};
            if ({dbp_r, db_r} != db_prev)       stab_cnt <= '0;
            else if (stab_cnt != CW'(DESKEW_CYC)) stab_cnt <= stab_cnt + 1'b1;
        end
    end

    assert_phase_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lines_r != $past(lines_r)) |-> !$past(bus_req) && !$past(ack_s));

    assert_req_interlock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> !$past(ack_s));

    assert_req_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> $past(ack_s));

    assert_deskew_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_req) && lines_r.io) |-> (stab_cnt >= LAST_CNT));

    assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && $past(bus_req)) |-> $stable(db_r) && $stable(dbp_r));

    assert_msgout_lines_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_mo && state != S_IDLE) |-> (lines_r == 3'b110));

endmodule

// File: rtl/ttx_retry.sv
// Command-phase parity retry counter.
// Assumes rx_* signals are single-cycle reports from the sequencer.
module ttx_retry #(
    parameter int MAX_RETRY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_valid,
    input  logic rx_perr,
    input  logic rx_is_cmd,
    input  logic rx_last,
    output logic cmd_retry,
    output logic cmd_escalate
);
    localparam int RW = $clog2(MAX_RETRY + 1);
    localparam logic [RW-1:0] RMAX = RW'(MAX_RETRY);

    logic [RW-1:0] tries;

    // Count command parity errors, escalate once retries are used up
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tries        <= '0;
            cmd_retry    <= 1'b0;
            cmd_escalate <= 1'b0;
        end else begin
            cmd_retry    <= 1'b0;
            cmd_escalate <= 1'b0;
            if (rx_valid && rx_is_cmd) begin
                if (rx_perr) begin
                    if (tries == RMAX) begin
                        cmd_escalate <= 1'b1;
                        tries        <= '0;
                    end else begin
                        cmd_retry <= 1'b1;
                        tries     <= tries + 1'b1;
                    end
                end else if (rx_last) begin
                    tries <= '0;
                end
            end
        end
    end

    assert_retry_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_retry || cmd_escalate) |-> $past(rx_valid && rx_perr && rx_is_cmd));

    assert_retry_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_retry, cmd_escalate}));

endmodule

// File: rtl/async_target_xfer.sv
// Top of the asynchronous target transfer engine: synchronizes ACK and
// ATN, runs the handshake sequencer and the command retry counter.
// Assumes active-high bus levels and a single initiator.
module async_target_xfer #(
    parameter int DESKEW_CYC  = 4,
    parameter int SYNC_STAGES = 2,
    parameter int MAX_RETRY   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [1:0] cmd_phase,
    input  logic       cmd_to_init,
    input  logic [7:0] cmd_data,
    input  logic       cmd_last,
    output logic       byte_done,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_perr,
    output logic       msgout_active,
    output logic       msgout_done,
    output logic       cmd_retry,
    output logic       cmd_escalate,
    output logic       bus_req,
    input  logic       bus_ack,
    input  logic       bus_atn,
    output logic       bus_cd,
    output logic       bus_io,
    output logic       bus_msg,
    output logic [7:0] bus_db_out,
    output logic       bus_dbp_out,
    output logic       bus_db_oe,
    input  logic [7:0] bus_db_in,
    input  logic       bus_dbp_in
);
    import ttx_pkg::*;

    logic [1:0] sync_q;
    logic       ack_s;
    logic       atn_s;
    logic       rx_is_cmd;
    logic       rx_last;
    ttx_lines_t lines;

    ttx_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({bus_atn, bus_ack}),
        .d_sync  (sync_q)
    );
    assign ack_s = sync_q[0];
    assign atn_s = sync_q[1];

    ttx_hs #(.DESKEW_CYC(DESKEW_CYC)) i_hs (
        .clk           (clk),
        .rst_n         (rst_n),
        .ack_s         (ack_s),
        .atn_s         (atn_s),
        .cmd_valid     (cmd_valid),
        .cmd_ready     (cmd_ready),
        .cmd_phase     (cmd_phase),
        .cmd_to_init   (cmd_to_init),
        .cmd_data      (cmd_data),
        .cmd_last      (cmd_last),
        .byte_done     (byte_done),
        .rx_valid      (rx_valid),
        .rx_data       (rx_data),
        .rx_perr       (rx_perr),
        .rx_is_cmd     (rx_is_cmd),
        .rx_last       (rx_last),
        .msgout_active (msgout_active),
        .msgout_done   (msgout_done),
        .bus_req       (bus_req),
        .lines         (lines),
        .db_out        (bus_db_out),
        .dbp_out       (bus_dbp_out),
        .db_oe         (bus_db_oe),
        .db_in         (bus_db_in),
        .dbp_in        (bus_dbp_in)
    );

    ttx_retry #(.MAX_RETRY(MAX_RETRY)) i_retry (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_perr      (rx_perr),
        .rx_is_cmd    (rx_is_cmd),
        .rx_last      (rx_last),
        .cmd_retry    (cmd_retry),
        .cmd_escalate (cmd_escalate)
    );

    assign bus_cd  = lines.cd;
    assign bus_io  = lines.io;
    assign bus_msg = lines.msg;

    assert_ready_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !bus_req);

endmodule

// File: tb/test_async_target_xfer.sv
// Directed bench: models the controller and the initiator.
module test_async_target_xfer;
    localparam int DESKEW = 4;
    localparam int MAXR   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_to_init = 1'b0, cmd_last = 1'b0;
    logic [1:0] cmd_phase = 2'd0;
    logic [7:0] cmd_data = 8'h00;
    logic bus_ack = 1'b0, bus_atn = 1'b0, bus_dbp_in = 1'b1;
    logic [7:0] bus_db_in = 8'h00;
    logic cmd_ready, byte_done, rx_valid, rx_perr, msgout_active, msgout_done;
    logic cmd_retry, cmd_escalate, bus_req, bus_cd, bus_io, bus_msg;
    logic [7:0] rx_data, bus_db_out;
    logic bus_dbp_out, bus_db_oe;

    int errors = 0, checks = 0;
    int n_retry = 0, n_esc = 0, n_mo_done = 0, rx_n = 0;
    int phase_viol = 0, deskew_viol = 0, stable_n = 0;
    logic [7:0] rx_log [32];
    logic       rx_perr_log [32];
    logic [2:0] prev_lines = 3'b000;
    logic [8:0] prev_db = 9'h100;
    logic       prev_req = 1'b0;

    always #10 clk = ~clk;

    async_target_xfer #(.DESKEW_CYC(DESKEW), .SYNC_STAGES(2), .MAX_RETRY(MAXR)) i_async_target_xfer (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_phase(cmd_phase), .cmd_to_init(cmd_to_init), .cmd_data(cmd_data),
        .cmd_last(cmd_last), .byte_done(byte_done), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_perr(rx_perr), .msgout_active(msgout_active),
        .msgout_done(msgout_done), .cmd_retry(cmd_retry), .cmd_escalate(cmd_escalate),
        .bus_req(bus_req), .bus_ack(bus_ack), .bus_atn(bus_atn), .bus_cd(bus_cd),
        .bus_io(bus_io), .bus_msg(bus_msg), .bus_db_out(bus_db_out),
        .bus_dbp_out(bus_dbp_out), .bus_db_oe(bus_db_oe), .bus_db_in(bus_db_in),
        .bus_dbp_in(bus_dbp_in)
    );

    // Monitors sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid && rx_n < 32) begin
                rx_log[rx_n] = rx_data;
                rx_perr_log[rx_n] = rx_perr;
                rx_n++;
            end
            if (cmd_retry) n_retry++;
            if (cmd_escalate) n_esc++;
            if (msgout_done) n_mo_done++;
            if ({bus_msg, bus_cd, bus_io} != prev_lines && (bus_req || bus_ack)) phase_viol++;
            if ({bus_dbp_out, bus_db_out} != prev_db) stable_n = 0;
            else stable_n++;
            if (bus_req && !prev_req && bus_io && stable_n < DESKEW) deskew_viol++;
        end
        prev_lines = {bus_msg, bus_cd, bus_io};
        prev_db = {bus_dbp_out, bus_db_out};
        prev_req = bus_req;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Controller issues one byte and waits until it completes
    task automatic ctl_send(input logic [1:0] ph, input logic ti, input logic [7:0] d, input logic last);
        @(negedge clk);
        cmd_phase = ph; cmd_to_init = ti; cmd_data = d; cmd_last = last; cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!byte_done) @(negedge clk);
    endtask

    // Initiator answers one REQ
    task automatic init_hs(input logic [7:0] d, input logic p, input logic drop_atn,
                           output logic [7:0] got_d, output logic got_p, output logic [2:0] got_l);
        @(negedge clk);
        while (!bus_req) @(negedge clk);
        got_l = {bus_msg, bus_cd, bus_io};
        got_d = bus_db_out;
        got_p = bus_dbp_out;
        bus_db_in = d; bus_dbp_in = p;
        repeat (2) @(negedge clk);
        if (drop_atn) bus_atn = 1'b0;
        bus_ack = 1'b1;
        while (bus_req) @(negedge clk);
        bus_ack = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(bus_req == 1'b0, "R10 req low", bus_req, 0);
        chk({bus_msg, bus_cd, bus_io} == 3'b000, "R10 phase lines", {bus_msg, bus_cd, bus_io}, 0);
        chk(bus_db_oe == 1'b0, "R10 oe low", bus_db_oe, 0);
        chk(cmd_ready == 1'b1, "R10 ready", cmd_ready, 1);
    endtask

    task automatic t_status_out;
        logic [7:0] gd; logic gp; logic [2:0] gl;
        fork
            ctl_send(2'd2, 1'b0, 8'hA5, 1'b1);
            init_hs(8'h00, 1'b1, 1'b0, gd, gp, gl);
        join
        chk(gl == 3'b011, "R1 status lines", gl, 3'b011);
        chk(gd == 8'hA5, "R4 status data", gd, 8'hA5);
        chk(gp == ~^8'hA5, "R4 odd parity", gp, ~^8'hA5);
        fork
            ctl_send(2'd3, 1'b1, 8'h80, 1'b1);
            init_hs(8'h00, 1'b1, 1'b0, gd, gp, gl);
        join
        chk(gl == 3'b111, "R1 msg-in lines", gl, 3'b111);
        chk(gp == 1'b0, "R4 odd parity 0x80", gp, 0);
        chk(deskew_viol == 0, "R4 deskew before REQ", deskew_viol, 0);
        chk(bus_req == 1'b0, "R3 req released", bus_req, 0);
    endtask

    task automatic t_command_in;
        logic [7:0] gd; logic gp; logic [2:0] gl;
        int base = rx_n;
        fork
            begin
                ctl_send(2'd1, 1'b1, 8'h00, 1'b0);
                ctl_send(2'd1, 1'b0, 8'h00, 1'b0);
                ctl_send(2'd1, 1'b0, 8'h00, 1'b1);
            end
            begin
                init_hs(8'h28, ~^8'h28, 1'b0, gd, gp, gl);
                chk(gl == 3'b010, "R1 command lines", gl, 3'b010);
                init_hs(8'h00, ~^8'h00, 1'b0, gd, gp, gl);
                init_hs(8'hFF, ~^8'hFF, 1'b0, gd, gp, gl);
            end
        join
        chk(rx_n == base + 3, "R5 rx count", rx_n - base, 3);
        chk(rx_log[base] == 8'h28 && rx_log[base+2] == 8'hFF, "R5 rx data", rx_log[base+2], 8'hFF);
        chk(rx_perr_log[base] == 0 && rx_perr_log[base+1] == 0, "R5 good parity", rx_perr_log[base+1], 0);
        chk(n_retry == 0, "R9 no retry on good", n_retry, 0);
    endtask

    task automatic t_data_dirs;
        logic [7:0] gd; logic gp; logic [2:0] gl;
        int base = rx_n;
        fork
            ctl_send(2'd0, 1'b0, 8'h00, 1'b1);
            init_hs(8'h3C, ~(~^8'h3C), 1'b0, gd, gp, gl);
        join
        chk(gl == 3'b000, "R1 data-out lines", gl, 0);
        chk(rx_perr_log[base] == 1'b1, "R5 parity error flagged", rx_perr_log[base], 1);
        chk(n_retry == 0, "R9 data perr no retry", n_retry, 0);
        fork
            ctl_send(2'd0, 1'b1, 8'h5A, 1'b1);
            init_hs(8'h00, 1'b1, 1'b0, gd, gp, gl);
        join
        chk(gl == 3'b001, "R1 data-in lines", gl, 3'b001);
        chk(gd == 8'h5A, "R4 data-in byte", gd, 8'h5A);
    endtask

    task automatic t_retry;
        logic [7:0] gd; logic gp; logic [2:0] gl;
        int r0 = n_retry, e0 = n_esc;
        fork
            begin
                ctl_send(2'd1, 1'b0, 8'h00, 1'b0);
                ctl_send(2'd1, 1'b0, 8'h00, 1'b1);
            end
            begin
                init_hs(8'h11, ~^8'h11 ^ 1'b1, 1'b0, gd, gp, gl);
                init_hs(8'h12, ~^8'h12, 1'b0, gd, gp, gl);
            end
        join
        repeat (2) @(negedge clk);
        chk(n_retry - r0 == 1, "R9 first retry", n_retry - r0, 1);
        for (int i = 0; i < MAXR; i++) begin
            fork
                ctl_send(2'd1, 1'b0, 8'h00, 1'b0);
                init_hs(8'h20, ~^8'h20 ^ 1'b1, 1'b0, gd, gp, gl);
            join
        end
        repeat (2) @(negedge clk);
        chk(n_retry - r0 == 1 + MAXR, "R9 count cleared by good last", n_retry - r0, 1 + MAXR);
        chk(n_esc == e0, "R9 no escalate yet", n_esc - e0, 0);
        fork
            ctl_send(2'd1, 1'b0, 8'h00, 1'b0);
            init_hs(8'h21, ~^8'h21 ^ 1'b1, 1'b0, gd, gp, gl);
        join
        repeat (2) @(negedge clk);
        chk(n_esc - e0 == 1, "R9 escalate", n_esc - e0, 1);
        chk(n_retry - r0 == 1 + MAXR, "R9 no retry on escalate", n_retry - r0, 1 + MAXR);
    endtask

    task automatic t_atn_command;
        logic [7:0] gd; logic gp; logic [2:0] gl1, gl2;
        int base, m0;
        fork
            ctl_send(2'd1, 1'b0, 8'h00, 1'b0);
            init_hs(8'h12, ~^8'h12, 1'b0, gd, gp, gl1);
        join
        bus_atn = 1'b1;
        repeat (4) @(negedge clk);
        base = rx_n; m0 = n_mo_done;
        fork
            ctl_send(2'd1, 1'b0, 8'h00, 1'b1);
            begin
                init_hs(8'h06, ~^8'h06, 1'b1, gd, gp, gl1);
                init_hs(8'h34, ~^8'h34, 1'b0, gd, gp, gl2);
            end
        join
        repeat (2) @(negedge clk);
        chk(gl1 == 3'b110, "R6 msg-out before next command byte", gl1, 3'b110);
        chk(gl2 == 3'b010, "R6 command resumes", gl2, 3'b010);
        chk(rx_log[base] == 8'h06 && rx_log[base+1] == 8'h34, "R6 byte order", rx_log[base], 8'h06);
        chk(n_mo_done - m0 == 1, "R8 msgout_done once", n_mo_done - m0, 1);
        chk(phase_viol == 0, "R2 phase lines only when idle", phase_viol, 0);
    endtask

    task automatic t_atn_data;
        logic [7:0] gd; logic gp; logic [2:0] gl;
        int m0 = n_mo_done;
        fork
            ctl_send(2'd0, 1'b1, 8'hC1, 1'b0);
            init_hs(8'h00, 1'b1, 1'b0, gd, gp, gl);
        join
        bus_atn = 1'b1;
        repeat (4) @(negedge clk);
        chk(msgout_active == 1'b0, "R7 no msg-out mid data", msgout_active, 0);
        fork
            ctl_send(2'd0, 1'b1, 8'hC2, 1'b1);
            init_hs(8'h00, 1'b1, 1'b0, gd, gp, gl);
        join
        chk(gl == 3'b001 && gd == 8'hC2, "R7 data continues under ATN", gl, 3'b001);
        init_hs(8'h07, ~^8'h07, 1'b0, gd, gp, gl);
        chk(gl == 3'b110, "R7 msg-out after last data", gl, 3'b110);
        init_hs(8'h08, ~^8'h08, 1'b1, gd, gp, gl);
        repeat (6) @(negedge clk);
        chk(n_mo_done - m0 == 1, "R8 done after ATN drop only", n_mo_done - m0, 1);
        chk(msgout_active == 1'b0 && cmd_ready == 1'b1, "R8 back to ready", cmd_ready, 1);
        chk(phase_viol == 0, "R2 no change during handshake", phase_viol, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_status_out();
        t_command_in();
        t_data_dirs();
        t_retry();
        t_atn_command();
        t_atn_data();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule